// File: doc/BRIEF.md
# Dual-Port Doorbell Register Pair

This block holds two 32-bit notification registers shared between a host-side register port and a local-side register port. In the downstream register, the host raises bits and the local side acknowledges them. In the upstream register, the local side raises bits and the host acknowledges them. Raising and acknowledging both use write-one semantics: a 1 acts on that bit, and a 0 leaves it alone. Each register drives a level interrupt toward the side that acknowledges it. A small control word holds one enable per interrupt.

Only one port is served in any cycle. A port that is granted keeps the grant for as long as it holds its request, so a multi-cycle access is never interleaved. A local request that loses is held off with its ready signal low. A host request that loses is answered with a retry. When two fresh requests arrive in the same cycle, the host wins by default.

Top module: `doorbell_pair`

## Requirements
- R1: After reset, both doorbell registers read 0, the control word reads 0 and both interrupts are low.
- R2: A served host write to selector 0 (downstream register) sets each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A served local write to selector 0 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A served local write to selector 1 (upstream register) sets the bits written as 1, and a served host write to selector 1 clears the bits written as 1. Bits written as 0 are unchanged in both cases.
- R5: Selector 2 is the control word, and either port can write it and read it back. Bit 0 enables the local interrupt and bit 1 enables the host interrupt. All other bits read 0.
- R6: `l_irq` is high exactly when control bit 0 is set and the downstream register is nonzero. `h_irq` is high exactly when control bit 1 is set and the upstream register is nonzero.
- R7: When the host holds the grant, or wins a fresh collision, a requesting local port sees `l_ready` low. `l_ready` is high whenever the local port is served or is not requesting.
- R8: When the local port holds the grant, a requesting host sees `h_retry` high. `h_retry` is low whenever the host is served or is not requesting.
- R9: When both ports request in the same cycle and neither held the grant on the previous cycle, the host is served.
- R10: A write that is stalled or retried changes no register.
- R11: Selector 3 reads 0, and writes to it change nothing.
- R12: Each port's read data always shows the current contents of the register it selects, whether or not that port is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 2 | Host register selector |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data |
| h_retry | output | 1 | Host access refused, try again |
| h_irq | output | 1 | Interrupt toward host (upstream pending) |
| l_req | input | 1 | Local access request |
| l_we | input | 1 | Local write (1) or read (0) |
| l_sel | input | 2 | Local register selector |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data |
| l_ready | output | 1 | Local access served this cycle |
| l_irq | output | 1 | Interrupt toward local side (downstream pending) |

## Verification
The assertions assume that each port keeps its request and write fields steady within a cycle. They also assume that a port reacts to a stall or retry only by repeating or dropping its request, and never treats the refused cycle as a completed write. The stimulus drives every input half a cycle away from the sampling edge. After a refusal, it either holds the request or releases it, so writes from both sides never land in the same cycle. This is what lets the set and clear checks look at each register one cycle after a served write.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  typedef enum logic [1:0] {
    SEL_DOWN = 2'd0,
    SEL_UP   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_VOID = 2'd3
  } dbell_sel_e;

  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_HOST  = 2'd1,
    OWN_LOCAL = 2'd2
  } dbell_owner_e;

  localparam int unsigned CTRL_W      = 2;
  localparam int unsigned CTRL_EN_LOC = 0;
  localparam int unsigned CTRL_EN_HST = 1;

endpackage

// File: rtl/dbell_arbiter.sv
module dbell_arbiter
  import dbell_pkg::*;
#(
  parameter bit HOST_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         h_req,
  input  logic         l_req,
  output logic         h_grant,
  output logic         l_grant,
  output dbell_owner_e owner_q
);

  dbell_owner_e owner_d;
  logic         host_keeps;
  logic         local_keeps;
  logic         fresh_clash;

  // the current owner keeps the grant as long as its request stays up
  assign host_keeps  = (owner_q == OWN_HOST)  && h_req;
  assign local_keeps = (owner_q == OWN_LOCAL) && l_req;
  assign fresh_clash = h_req && l_req && !host_keeps && !local_keeps;

  always_comb begin
    h_grant = 1'b0;
    l_grant = 1'b0;
    if (host_keeps) begin
      h_grant = 1'b1;
    end else if (local_keeps) begin
      l_grant = 1'b1;
    end else if (fresh_clash) begin
      if (HOST_FIRST) h_grant = 1'b1;
      else            l_grant = 1'b1;
    end else if (h_req) begin
      h_grant = 1'b1;
    end else if (l_req) begin
      l_grant = 1'b1;
    end
  end

  always_comb begin
    if (h_grant)      owner_d = OWN_HOST;
    else if (l_grant) owner_d = OWN_LOCAL;
    else              owner_d = OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_IDLE;
    else        owner_q <= owner_d;
  end

endmodule

// File: rtl/dbell_bits.sv
module dbell_bits #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_mask,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] q
);

  logic [DW-1:0] set_hit;
  logic [DW-1:0] clr_hit;

  assign set_hit = set_en ? set_mask : '0;
  assign clr_hit = clr_en ? clr_mask : '0;

  // per-bit storage; a set beats a clear so no notification is dropped
  for (genvar b = 0; b < DW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          q[b] <= 1'b0;
      else if (set_hit[b]) q[b] <= 1'b1;
      else if (clr_hit[b]) q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/dbell_port.sv
module dbell_port
  import dbell_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                req,
  input  logic                we,
  input  logic [1:0]          sel,
  input  logic [DW-1:0]       wdata,
  input  logic                grant,
  input  logic [DW-1:0]       down_q,
  input  logic [DW-1:0]       up_q,
  input  logic [CTRL_W-1:0]   ctrl_q,
  output logic                wr_down,
  output logic                wr_up,
  output logic                wr_ctrl,
  output logic                refused,
  output logic [DW-1:0]       rdata
);

  logic served_wr;

  function automatic logic [DW-1:0] pick_read(
    input logic [1:0]        s,
    input logic [DW-1:0]     dq,
    input logic [DW-1:0]     uq,
    input logic [CTRL_W-1:0] cq
  );
    logic [DW-1:0] r;
    case (dbell_sel_e'(s))
      SEL_DOWN: r = dq;
      SEL_UP:   r = uq;
      SEL_CTRL: r = {{(DW-CTRL_W){1'b0}}, cq};
      default:  r = '0;
    endcase
    return r;
  endfunction

  assign served_wr = req && grant && we;
  assign wr_down   = served_wr && (sel == SEL_DOWN);
  assign wr_up     = served_wr && (sel == SEL_UP);
  assign wr_ctrl   = served_wr && (sel == SEL_CTRL);
  assign refused   = req && !grant;
  assign rdata     = pick_read(sel, down_q, up_q, ctrl_q);

  logic unused_ok;
  assign unused_ok = ^wdata;

endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair
  import dbell_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          HOST_FIRST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [1:0]    h_sel,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_retry,
  output logic          h_irq,
  input  logic          l_req,
  input  logic          l_we,
  input  logic [1:0]    l_sel,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_ready,
  output logic          l_irq
);

  // named internal events, visible to the bound checker
  logic              h_grant;
  logic              l_grant;
  dbell_owner_e      owner_q;
  logic [DW-1:0]     down_q;
  logic [DW-1:0]     up_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              h_wr_down, h_wr_up, h_wr_ctrl, h_refused;
  logic              l_wr_down, l_wr_up, l_wr_ctrl, l_refused;
  logic              en_local;
  logic              en_host;

  dbell_arbiter #(.HOST_FIRST(HOST_FIRST)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_req   (h_req),
    .l_req   (l_req),
    .h_grant (h_grant),
    .l_grant (l_grant),
    .owner_q (owner_q)
  );

  dbell_port #(.DW(DW)) u_hport (
    .req     (h_req),
    .we      (h_we),
    .sel     (h_sel),
    .wdata   (h_wdata),
    .grant   (h_grant),
    .down_q  (down_q),
    .up_q    (up_q),
    .ctrl_q  (ctrl_q),
    .wr_down (h_wr_down),
    .wr_up   (h_wr_up),
    .wr_ctrl (h_wr_ctrl),
    .refused (h_refused),
    .rdata   (h_rdata)
  );

  dbell_port #(.DW(DW)) u_lport (
    .req     (l_req),
    .we      (l_we),
    .sel     (l_sel),
    .wdata   (l_wdata),
    .grant   (l_grant),
    .down_q  (down_q),
    .up_q    (up_q),
    .ctrl_q  (ctrl_q),
    .wr_down (l_wr_down),
    .wr_up   (l_wr_up),
    .wr_ctrl (l_wr_ctrl),
    .refused (l_refused),
    .rdata   (l_rdata)
  );

  // downstream: host raises, local acknowledges
  dbell_bits #(.DW(DW)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (h_wr_down),
    .set_mask (h_wdata),
    .clr_en   (l_wr_down),
    .clr_mask (l_wdata),
    .q        (down_q)
  );

  // upstream: local raises, host acknowledges
  dbell_bits #(.DW(DW)) u_up (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (l_wr_up),
    .set_mask (l_wdata),
    .clr_en   (h_wr_up),
    .clr_mask (h_wdata),
    .q        (up_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (h_wr_ctrl) ctrl_q <= h_wdata[CTRL_W-1:0];
    else if (l_wr_ctrl) ctrl_q <= l_wdata[CTRL_W-1:0];
  end

  assign en_local = ctrl_q[CTRL_EN_LOC];
  assign en_host  = ctrl_q[CTRL_EN_HST];

  assign l_irq   = en_local && (|down_q);
  assign h_irq   = en_host  && (|up_q);
  assign h_retry = h_refused;
  assign l_ready = !l_refused;

endmodule

// File: rtl/dbell_pair_chk.sv
module dbell_pair_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_we,
  input logic [1:0]    h_sel,
  input logic [DW-1:0] h_wdata,
  input logic          h_retry,
  input logic          h_irq,
  input logic          l_req,
  input logic          l_we,
  input logic [1:0]    l_sel,
  input logic [DW-1:0] l_wdata,
  input logic          l_ready,
  input logic          l_irq,
  input logic [DW-1:0] down_q,
  input logic [DW-1:0] up_q,
  input logic          en_local,
  input logic          en_host
);

  logic h_served, l_served;
  assign h_served = h_req && !h_retry;
  assign l_served = l_req && l_ready;

  assert_host_sets_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_served && h_we && h_sel == 2'd0) |=> ((down_q & $past(h_wdata)) == $past(h_wdata)));

  assert_local_clears_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_served && l_we && l_sel == 2'd0) |=> ((down_q & $past(l_wdata)) == '0));

  assert_local_sets_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_served && l_we && l_sel == 2'd1) |=> ((up_q & $past(l_wdata)) == $past(l_wdata)));

  assert_host_clears_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_served && h_we && h_sel == 2'd1) |=> ((up_q & $past(h_wdata)) == '0));

  assert_local_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l_irq |-> (en_local && down_q != '0));

  assert_host_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> (en_host && up_q != '0));

  assert_local_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_served && l_req) |-> !l_ready);

  assert_host_retried_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_served && h_req) |-> h_retry);

  assert_one_served_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_served && l_served));

  assert_void_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_served && h_we && h_sel == 2'd3) |=> ($stable(down_q) && $stable(up_q)));

endmodule

bind doorbell_pair dbell_pair_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .h_req    (h_req),
  .h_we     (h_we),
  .h_sel    (h_sel),
  .h_wdata  (h_wdata),
  .h_retry  (h_retry),
  .h_irq    (h_irq),
  .l_req    (l_req),
  .l_we     (l_we),
  .l_sel    (l_sel),
  .l_wdata  (l_wdata),
  .l_ready  (l_ready),
  .l_irq    (l_irq),
  .down_q   (down_q),
  .up_q     (up_q),
  .en_local (en_local),
  .en_host  (en_host)
);

// File: tb/doorbell_pair_tb.sv
module doorbell_pair_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 0, h_we = 0, l_req = 0, l_we = 0;
  logic [1:0]  h_sel = 0, l_sel = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic        h_retry, h_irq, l_ready, l_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // reference state: plain variables, updated behaviourally
  logic [31:0] m_down = 0, m_up = 0;
  int          m_ctrl = 0;
  int          m_owner = 0;   // 0 idle, 1 host, 2 local
  bit          m_hg, m_lg;

  always #10 clk = ~clk;

  doorbell_pair dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_retry(h_retry), .h_irq(h_irq),
    .l_req(l_req), .l_we(l_we), .l_sel(l_sel), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_ready(l_ready), .l_irq(l_irq)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [1:0] s);
    if (s == 2'd0) return m_down;
    if (s == 2'd1) return m_up;
    if (s == 2'd2) return 32'(m_ctrl);
    return 32'h0;
  endfunction

  // one cycle: drive at negedge, compare mid-low phase, advance model at posedge
  task automatic step(bit hr, bit hw, logic [1:0] hs, logic [31:0] hd,
                      bit lr, bit lw, logic [1:0] ls, logic [31:0] ld);
    @(negedge clk);
    h_req = hr; h_we = hw; h_sel = hs; h_wdata = hd;
    l_req = lr; l_we = lw; l_sel = ls; l_wdata = ld;
    #5;
    m_hg = 0; m_lg = 0;
    if (hr && m_owner == 1)      m_hg = 1;
    else if (lr && m_owner == 2) m_lg = 1;
    else if (hr)                 m_hg = 1;
    else if (lr)                 m_lg = 1;
    chk("h_retry", 32'(h_retry), 32'(hr && !m_hg));
    chk("l_ready", 32'(l_ready), 32'(!(lr && !m_lg)));
    chk("h_rdata", h_rdata, m_read(hs));
    chk("l_rdata", l_rdata, m_read(ls));
    chk("l_irq", 32'(l_irq), 32'(m_ctrl[0] && m_down != 0));
    chk("h_irq", 32'(h_irq), 32'(m_ctrl[1] && m_up != 0));
    @(posedge clk);
    if (m_hg && hw) begin
      if (hs == 2'd0)      m_down = m_down | hd;
      else if (hs == 2'd1) m_up = m_up & ~hd;
      else if (hs == 2'd2) m_ctrl = int'(hd & 32'h3);
    end
    if (m_lg && lw) begin
      if (ls == 2'd0)      m_down = m_down & ~ld;
      else if (ls == 2'd1) m_up = m_up | ld;
      else if (ls == 2'd2) m_ctrl = int'(ld & 32'h3);
    end
    m_owner = m_hg ? 1 : (m_lg ? 2 : 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset contents seen from both ports
    cur_tag = "R1";
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 0, 1, 0, 0, 0, 2, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    idle();
    // R2: host sets downstream bits, zeros do nothing
    cur_tag = "R2";
    step(1, 1, 0, 32'h0000_00F0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h8000_0003, 0, 0, 0, 0);
    step(1, 1, 0, 32'h0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    idle();
    // R3: local clears downstream bits
    cur_tag = "R3";
    step(0, 0, 0, 0, 1, 1, 0, 32'h0000_0030);
    step(0, 0, 0, 0, 1, 1, 0, 32'h0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    idle();
    // R4: local sets upstream, host clears it
    cur_tag = "R4";
    step(0, 0, 0, 0, 1, 1, 1, 32'h00A5_00A5);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h0000_0005, 0, 0, 1, 0);
    step(1, 0, 1, 0, 0, 0, 1, 0);
    idle();
    // R5: control word from either side
    cur_tag = "R5";
    step(1, 1, 2, 32'hFFFF_FFFD, 0, 0, 2, 0);
    step(0, 0, 2, 0, 1, 0, 2, 0);
    step(0, 0, 2, 0, 1, 1, 2, 32'h0000_0003);
    step(1, 0, 2, 0, 0, 0, 2, 0);
    idle();
    // R6: interrupts follow contents and enables
    cur_tag = "R6";
    step(0, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h0000_0100, 0, 0, 0, 0);
    step(1, 1, 2, 32'h0000_0001, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 2, 32'h0000_0002);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle();
    // R7: host keeps the grant, local is held off
    cur_tag = "R7";
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 32'h0000_0002, 1, 1, 0, 32'h0000_0100);
    step(1, 0, 1, 0, 1, 1, 0, 32'h0000_0100);
    step(0, 0, 0, 0, 1, 1, 0, 32'h0000_0100);
    // R8: local keeps the grant, host is retried
    cur_tag = "R8";
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    idle();
    // R9: fresh collision goes to the host
    cur_tag = "R9";
    step(1, 1, 0, 32'h0000_0040, 1, 1, 1, 32'h0000_0008);
    step(0, 0, 1, 0, 1, 0, 1, 0);
    idle();
    // R10: refused writes leave every register alone
    cur_tag = "R10";
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 1, 0, 32'h0001_0000, 1, 0, 0, 0);
    step(1, 1, 2, 32'h0000_0000, 1, 0, 2, 0);
    step(1, 0, 0, 0, 1, 1, 1, 32'h0000_0001);
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 32'h0000_0008, 1, 1, 0, 32'hFFFF_FFFF);
    step(1, 0, 0, 0, 1, 0, 0, 0);
    idle();
    // R11: unused selector
    cur_tag = "R11";
    step(1, 1, 3, 32'hFFFF_FFFF, 0, 0, 3, 0);
    step(0, 0, 0, 0, 1, 1, 3, 32'hFFFF_FFFF);
    step(1, 0, 3, 0, 0, 0, 0, 0);
    idle();
    // R12: reads from the refused side still track contents
    cur_tag = "R12";
    step(1, 1, 0, 32'h0F00_0000, 1, 0, 0, 0);
    step(1, 0, 1, 0, 1, 0, 0, 0);
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule